// File: doc/BRIEF.md
# Paged Host Register Block with Interrupt Control

This block is the host-facing register front end of a network controller. A host reaches sixteen byte-wide addresses. A command register sits at address 0x00 and is visible on every page. Its top two bits pick the page that the other fifteen addresses decode to. The command register also holds the run controls (start, stop), the transmit request and a three-bit remote DMA command. These fields are driven out to the controller core.

Single-cycle event pulses arrive from the receive, transmit and DMA logic. Each pulse latches a bit in an interrupt status register, and the host clears those bits by writing ones. A mask register gates the latched bits onto one level-sensitive interrupt line. Three error tally counters (alignment, CRC and missed frames) count their own event pulses and clear when the host reads them. When a counter crosses into its upper half, it raises the counter-overflow status bit. The asynchronous reset input is released to the logic through a two-stage synchroniser.

Top module: `netctl_regfile`

## Requirements
- R1: After reset the command register reads 0x21 (bit 0 stop set, bits 5:3 = 100 abort). Status, mask and all tallies read 0, and `irq` is low.
- R2: Address 0x00 reads and writes the command register on every page. Bits 7:6 select the page (00, 01, 10, 11). Bit 0 drives `run_stop`, bit 1 drives `run_start`, and bits 5:3 drive `dma_cmd` (001 read, 010 write, 011 send, 1xx abort).
- R3: Command bit 2 (`tx_go`) is set by writing it as 1, and writing it as 0 leaves it unchanged. A pulse on `ev_tx_ok` or `ev_tx_err` clears it, unless a write in the same cycle sets it again.
- R4: Each event pulse sets its status bit on the next clock: bit 0 `ev_rx_ok`, bit 1 `ev_tx_ok`, bit 2 `ev_rx_err`, bit 3 `ev_tx_err`, bit 4 `ev_ring_ovw`, bit 6 `ev_dma_done`. Setting wins over a clear in the same cycle.
- R5: On page 0, the status register reads at 0x07. Writing 1 to a bit at 0x07 clears that bit, and writing 0 leaves it unchanged.
- R6: Status bit 7 becomes set on the clock after a cycle in which command bit 0 is 1 and `core_idle` is high.
- R7: The mask register is written at page 0 address 0x0F and read at page 2 address 0x0F, with the same bit layout as the status register. `irq` is high exactly when (status AND mask) is nonzero.
- R8: On page 0, reads of 0x0D, 0x0E and 0x0F return the alignment, CRC and missed-frame tallies, zero-extended to 8 bits. Each tally counts its pulses and holds at all ones.
- R9: A read strobe (`host_rd`) on page 0 at a tally address clears that tally on the next clock. If an event for that tally arrives in the same cycle, the tally becomes 1.
- R10: Status bit 5 is set on the clock at which any tally's most significant bit changes from 0 to 1.
- R11: On pages 1, 2 and 3, writes to any address other than 0x00 have no effect, and reads return 0, except for the mask read of R7. On page 0, addresses not named above read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Register address |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, clears a tally when it addresses one |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| irq | output | 1 | Level interrupt request |
| run_stop | output | 1 | Command stop bit |
| run_start | output | 1 | Command start bit |
| tx_go | output | 1 | Transmit request bit |
| dma_cmd | output | 3 | Remote DMA command field |
| ev_rx_ok | input | 1 | Frame received pulse |
| ev_tx_ok | input | 1 | Frame sent pulse |
| ev_rx_err | input | 1 | Receive error pulse |
| ev_tx_err | input | 1 | Transmit error pulse |
| ev_ring_ovw | input | 1 | Receive ring overwrite warning pulse |
| ev_dma_done | input | 1 | Remote DMA finished pulse |
| core_idle | input | 1 | Controller core idle level |
| ev_align_err | input | 1 | Alignment error pulse |
| ev_crc_err | input | 1 | CRC error pulse |
| ev_missed | input | 1 | Missed frame pulse |

## Verification
The bench builds the block with `CNT_W = 4`, where the default is 8. With that width a tally crosses its most significant bit after eight pulses and saturates at 15. This puts the overflow bit, saturation and read-clear-versus-increment collisions within a few dozen cycles. Page switching, status clearing by ones, and set-versus-clear and transmit-clear-versus-rewrite collisions are exercised at this width against the behavioural model.

// File: rtl/netctl_pkg.sv
package netctl_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned NUM_TALLY = 3;

  typedef enum logic [1:0] {
    PG_MAIN = 2'd0,
    PG_ALT  = 2'd1,
    PG_CFG  = 2'd2,
    PG_RSVD = 2'd3
  } page_e;

  localparam logic [ADDR_W-1:0] A_CMD    = 4'h0;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'h7;
  localparam logic [ADDR_W-1:0] A_TALLY0 = 4'hD;
  localparam logic [ADDR_W-1:0] A_MASK   = 4'hF;

  localparam int unsigned ST_RX_OK  = 0;
  localparam int unsigned ST_TX_OK  = 1;
  localparam int unsigned ST_RX_ERR = 2;
  localparam int unsigned ST_TX_ERR = 3;
  localparam int unsigned ST_OVW    = 4;
  localparam int unsigned ST_CNT    = 5;
  localparam int unsigned ST_DMA    = 6;
  localparam int unsigned ST_RESET  = 7;

  localparam int unsigned CB_STOP = 0;
  localparam int unsigned CB_TXGO = 2;

  localparam logic [DATA_W-1:0] CMD_RESET = 8'h21;
endpackage

// File: rtl/netctl_rst_sync.sv
module netctl_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/netctl_cmd_reg.sv
module netctl_cmd_reg
  import netctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tx_done_i,
  output logic [DATA_W-1:0] cmd_o
);
  logic [DATA_W-1:0] cmd_q, cmd_d;
  logic              cmd_en;

  always_comb begin
    cmd_d  = cmd_q;
    cmd_en = wr_i | tx_done_i;
    if (wr_i) begin
      cmd_d          = wdata_i;
      cmd_d[CB_TXGO] = wdata_i[CB_TXGO] | (cmd_q[CB_TXGO] & ~tx_done_i);
    end else if (tx_done_i) begin
      cmd_d[CB_TXGO] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cmd_q <= CMD_RESET;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  assign cmd_o = cmd_q;

  // R3: a pending transmit request survives until completion or rewrite
  a_r3_txp_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_q[CB_TXGO] && !tx_done_i && !wr_i) |=> cmd_q[CB_TXGO]);

  // R3: completion drops the request unless rewritten as 1
  a_r3_txp_drop: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_done_i && !(wr_i && wdata_i[CB_TXGO])) |=> !cmd_q[CB_TXGO]);
endmodule

// File: rtl/netctl_int_ctrl.sv
module netctl_int_ctrl
  import netctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  input  logic              mask_wr_i,
  input  logic [DATA_W-1:0] mask_wdata_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] status_q, status_d;
  logic [DATA_W-1:0] mask_q;
  logic              status_en;

  always_comb begin
    status_en = (set_i != '0) || (clr_i != '0);
    status_d  = (status_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)        status_q <= '0;
    else if (status_en) status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_wr_i) mask_q <= mask_wdata_i;
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & mask_q);

  // R4: every incoming event is latched on the next edge
  a_r4_set_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

  // R5: a ones-write with no competing event empties those bits
  a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_ni)
    ((clr_i != '0) && (set_i == '0)) |=> ((status_q & $past(clr_i)) == '0));
endmodule

// File: rtl/netctl_tally.sv
module netctl_tally #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic             cnt_en;

  always_comb begin
    base   = clr_i ? '0 : cnt_q;
    cnt_d  = (inc_i && (base != MAX)) ? base + CNT_W'(1) : base;
    cnt_en = inc_i | clr_i;
    ovf_o  = cnt_en & cnt_d[CNT_W-1] & ~cnt_q[CNT_W-1];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R8: a full tally stays full while not read
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_ni)
    ((cnt_q == MAX) && !clr_i) |=> (cnt_q == MAX));

  // R9: a read without a coincident event leaves zero
  a_r9_read_clear: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_i && !inc_i) |=> (cnt_q == '0));
endmodule

// File: rtl/netctl_regfile.sv
module netctl_regfile
  import netctl_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq,
  output logic              run_stop,
  output logic              run_start,
  output logic              tx_go,
  output logic [2:0]        dma_cmd,
  input  logic              ev_rx_ok,
  input  logic              ev_tx_ok,
  input  logic              ev_rx_err,
  input  logic              ev_tx_err,
  input  logic              ev_ring_ovw,
  input  logic              ev_dma_done,
  input  logic              core_idle,
  input  logic              ev_align_err,
  input  logic              ev_crc_err,
  input  logic              ev_missed
);
  logic              rst_sync_n;
  logic [DATA_W-1:0] cmd_q, status, mask;
  logic [DATA_W-1:0] set_vec, clr_vec;
  page_e             page;
  logic              on_main, cmd_wr, mask_wr, tx_done;
  logic [NUM_TALLY-1:0] tally_ev, tally_clr, tally_ovf;
  logic [CNT_W-1:0]  tally_cnt [NUM_TALLY];

  netctl_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  assign page    = page_e'(cmd_q[7:6]);
  assign on_main = (page == PG_MAIN);
  assign cmd_wr  = host_wr && (host_addr == A_CMD);
  assign mask_wr = host_wr && on_main && (host_addr == A_MASK);
  assign clr_vec = (host_wr && on_main && (host_addr == A_STAT)) ? host_wdata : '0;
  assign tx_done = ev_tx_ok | ev_tx_err;

  netctl_cmd_reg u_cmd (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .wr_i      (cmd_wr),
    .wdata_i   (host_wdata),
    .tx_done_i (tx_done),
    .cmd_o     (cmd_q)
  );

  assign tally_ev = {ev_missed, ev_crc_err, ev_align_err};

  for (genvar g = 0; g < NUM_TALLY; g++) begin : g_tally
    localparam logic [ADDR_W-1:0] SLOT = A_TALLY0 + ADDR_W'(g);
    assign tally_clr[g] = host_rd && on_main && (host_addr == SLOT);
    netctl_tally #(.CNT_W(CNT_W)) u_tally (
      .clk    (clk),
      .rst_ni (rst_sync_n),
      .inc_i  (tally_ev[g]),
      .clr_i  (tally_clr[g]),
      .cnt_o  (tally_cnt[g]),
      .ovf_o  (tally_ovf[g])
    );
  end

  always_comb begin
    set_vec            = '0;
    set_vec[ST_RX_OK]  = ev_rx_ok;
    set_vec[ST_TX_OK]  = ev_tx_ok;
    set_vec[ST_RX_ERR] = ev_rx_err;
    set_vec[ST_TX_ERR] = ev_tx_err;
    set_vec[ST_OVW]    = ev_ring_ovw;
    set_vec[ST_CNT]    = |tally_ovf;
    set_vec[ST_DMA]    = ev_dma_done;
    set_vec[ST_RESET]  = cmd_q[CB_STOP] & core_idle;
  end

  netctl_int_ctrl u_int (
    .clk          (clk),
    .rst_ni       (rst_sync_n),
    .set_i        (set_vec),
    .clr_i        (clr_vec),
    .mask_wr_i    (mask_wr),
    .mask_wdata_i (host_wdata),
    .status_o     (status),
    .mask_o       (mask),
    .irq_o        (irq)
  );

  always_comb begin
    host_rdata = '0;
    if (host_addr == A_CMD) begin
      host_rdata = cmd_q;
    end else begin
      unique case (page)
        PG_MAIN: begin
          if (host_addr == A_STAT) host_rdata = status;
          for (int k = 0; k < NUM_TALLY; k++) begin
            if (host_addr == (A_TALLY0 + ADDR_W'(k))) host_rdata = DATA_W'(tally_cnt[k]);
          end
        end
        PG_CFG: begin
          if (host_addr == A_MASK) host_rdata = mask;
        end
        default: host_rdata = '0;
      endcase
    end
  end

  assign run_stop  = cmd_q[CB_STOP];
  assign run_start = cmd_q[1];
  assign tx_go     = cmd_q[CB_TXGO];
  assign dma_cmd   = cmd_q[5:3];

  // R6: stopped and idle raises the reset-status bit on the next edge
  a_r6_stop_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_stop && core_idle) |=> status[ST_RESET]);

  // R11: status writes off page 0 change nothing
  a_r11_off_page: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_wr && !on_main && (host_addr == A_STAT) && (set_vec == '0)) |=> $stable(status));
endmodule

// File: tb/netctl_regfile_test.sv
`timescale 1ns/1ps
module netctl_regfile_test;
  localparam int CW   = 4;
  localparam int HALF = 1 << (CW - 1);
  localparam int MAXV = (1 << CW) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] host_addr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       irq, run_stop, run_start, tx_go;
  logic [2:0] dma_cmd;
  logic [9:0] ev = '0;

  netctl_regfile #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .run_stop(run_stop), .run_start(run_start), .tx_go(tx_go),
    .dma_cmd(dma_cmd), .ev_rx_ok(ev[0]), .ev_tx_ok(ev[1]), .ev_rx_err(ev[2]),
    .ev_tx_err(ev[3]), .ev_ring_ovw(ev[4]), .ev_dma_done(ev[5]),
    .core_idle(ev[6]), .ev_align_err(ev[7]), .ev_crc_err(ev[8]),
    .ev_missed(ev[9])
  );

  always #2.5 clk = ~clk;

  int    checks = 0, errors = 0;
  bit    done = 0;
  string req = "R1";

  logic [7:0] m_cmd, m_isr, m_imr;
  int         m_cnt [3];

  function automatic logic [7:0] m_read(logic [3:0] a);
    logic [1:0] pg = m_cmd[7:6];
    if (a == 4'h0) return m_cmd;
    if (pg == 2'd0) begin
      if (a == 4'h7) return m_isr;
      if (a >= 4'hD) return 8'(m_cnt[a - 4'hD]);
    end
    if (pg == 2'd2 && a == 4'hF) return m_imr;
    return 8'h00;
  endfunction

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_step(logic [3:0] a, logic w, logic r, logic [7:0] d, logic [9:0] e);
    logic [1:0] pg = m_cmd[7:6];
    logic ovf = 0;
    logic done_tx = e[1] | e[3];
    logic [7:0] setv, clrv, nc;
    for (int k = 0; k < 3; k++) begin
      int base = (r && pg == 2'd0 && a == 4'(13 + k)) ? 0 : m_cnt[k];
      int nv = (e[7+k] && base != MAXV) ? base + 1 : base;
      if (nv >= HALF && m_cnt[k] < HALF) ovf = 1;
      m_cnt[k] = nv;
    end
    setv = {m_cmd[0] & e[6], e[5], ovf, e[4], e[3], e[2], e[1], e[0]};
    clrv = (w && pg == 2'd0 && a == 4'h7) ? d : 8'h00;
    m_isr = (m_isr & ~clrv) | setv;
    if (w && pg == 2'd0 && a == 4'hF) m_imr = d;
    nc = m_cmd;
    if (w && a == 4'h0) begin
      nc = d;
      nc[2] = d[2] | (m_cmd[2] & ~done_tx);
    end else if (done_tx) nc[2] = 1'b0;
    m_cmd = nc;
  endtask

  // one clock: drive at negedge, compare before the edge, advance model after it
  task automatic cyc(logic [3:0] a, logic w, logic r, logic [7:0] d, logic [9:0] e);
    host_addr = a; host_wr = w; host_rd = r; host_wdata = d; ev = e;
    #1;
    chk("rdata", host_rdata, m_read(a));
    chk("irq", 8'(irq), 8'(|(m_isr & m_imr)));
    chk("cmd outs", {2'b00, dma_cmd, tx_go, run_start, run_stop}, {2'b00, m_cmd[5:0]});
    @(posedge clk);
    #0.5;
    model_step(a, w, r, d, e);
    @(negedge clk);
    host_wr = 0; host_rd = 0; ev = '0;
  endtask

  task automatic lit(logic [3:0] a, logic [7:0] exp);
    host_addr = a; host_wr = 0; host_rd = 0; ev = '0;
    #1;
    chk("literal", host_rdata, exp);
    cyc(a, 0, 0, 8'h00, '0);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d); cyc(a, 1, 0, d, '0); endtask
  task automatic pulse(logic [9:0] e);             cyc(4'h0, 0, 0, 8'h00, e); endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_cmd = 8'h21; m_isr = 0; m_imr = 0;
    for (int k = 0; k < 3; k++) m_cnt[k] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);

    req = "R1";
    lit(4'h0, 8'h21); lit(4'h7, 8'h00); lit(4'hD, 8'h00);
    chk("irq reset", 8'(irq), 8'h00);

    req = "R2";
    wr(4'h0, 8'h22); lit(4'h0, 8'h22);
    chk("start", 8'(run_start), 8'h01);
    wr(4'h0, 8'h4A); lit(4'h0, 8'h4A);
    chk("dma read", 8'(dma_cmd), 8'h01);
    wr(4'h0, 8'hDA); lit(4'h0, 8'hDA);
    wr(4'h0, 8'h22);

    req = "R3";
    wr(4'h0, 8'h26); lit(4'h0, 8'h26);
    wr(4'h0, 8'h22); lit(4'h0, 8'h26);
    pulse(10'b00_0000_0010); lit(4'h0, 8'h22);
    cyc(4'h0, 1, 0, 8'h26, 10'b00_0000_1000); lit(4'h0, 8'h26);
    pulse(10'b00_0000_1000); lit(4'h0, 8'h22);
    wr(4'h7, 8'hFF); lit(4'h7, 8'h00);

    req = "R4";
    pulse(10'b00_0000_0001); lit(4'h7, 8'h01);
    pulse(10'b00_0000_0100); pulse(10'b00_0001_0000); pulse(10'b00_0010_0000);
    lit(4'h7, 8'h55);
    cyc(4'h7, 1, 0, 8'h01, 10'b00_0000_0001); lit(4'h7, 8'h55);

    req = "R5";
    wr(4'h7, 8'h00); lit(4'h7, 8'h55);
    wr(4'h7, 8'h14); lit(4'h7, 8'h41);
    wr(4'h7, 8'hFF); lit(4'h7, 8'h00);

    req = "R7";
    wr(4'hF, 8'h02); chk("irq masked off", 8'(irq), 8'h00);
    pulse(10'b00_0000_0001); chk("irq other bit", 8'(irq), 8'h00);
    pulse(10'b00_0000_0010); chk("irq on", 8'(irq), 8'h01);
    wr(4'h7, 8'h02); chk("irq off", 8'(irq), 8'h00);
    wr(4'h0, 8'hA2); lit(4'hF, 8'h02); lit(4'h7, 8'h00);

    req = "R11";
    wr(4'h0, 8'h62);
    wr(4'h7, 8'hFF); wr(4'hF, 8'hFF); lit(4'h7, 8'h00); lit(4'hD, 8'h00);
    wr(4'h0, 8'h22); lit(4'h7, 8'h01); lit(4'h3, 8'h00);
    wr(4'h0, 8'hA2); lit(4'hF, 8'h02); wr(4'h0, 8'h22);
    wr(4'h7, 8'hFF);

    req = "R8";
    repeat (3) pulse(10'b00_1000_0000);
    pulse(10'b01_0000_0000);
    repeat (5) pulse(10'b10_0000_0000);
    lit(4'hD, 8'h03); lit(4'hE, 8'h01); lit(4'hF, 8'h05);

    req = "R9";
    cyc(4'hD, 0, 1, 8'h00, '0); lit(4'hD, 8'h00);
    cyc(4'hE, 0, 1, 8'h00, 10'b01_0000_0000); lit(4'hE, 8'h01);

    req = "R10";
    lit(4'h7, 8'h00);
    repeat (2) pulse(10'b10_0000_0000); lit(4'h7, 8'h00);
    pulse(10'b10_0000_0000); lit(4'h7, 8'h20); lit(4'hF, 8'h08);
    wr(4'h7, 8'h20);

    req = "R8";
    repeat (12) pulse(10'b10_0000_0000); lit(4'hF, 8'h0F);
    cyc(4'hF, 0, 1, 8'h00, '0); lit(4'hF, 8'h00);
    wr(4'h7, 8'hFF);

    req = "R6";
    cyc(4'h0, 0, 0, 8'h00, 10'b00_0100_0000); lit(4'h7, 8'h00);
    wr(4'h0, 8'h21);
    cyc(4'h0, 0, 0, 8'h00, 10'b00_0100_0000); lit(4'h7, 8'h80);
    cyc(4'h7, 1, 0, 8'h80, 10'b00_0100_0000); lit(4'h7, 8'h80);
    wr(4'h7, 8'h80); lit(4'h7, 8'h00);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule